// File: doc/BRIEF.md
# Forwarded Clock Pattern Generator

This block turns one serializer data lane into a forwarded clock output. It runs on the serial-rate clock. Each cycle it emits one bit of a repeating pattern. The pattern makes the lane toggle at the data rate or at the data rate divided by a selectable ratio, so a receiver gets a clock that sits next to the data pins and travels through the same output path.

The pattern restarts at every word boundary of the serializer, which comes every `ser_factor` serial bits, counted from reset release. Clock edges therefore keep a fixed relation to the word edges of the neighbouring data lanes. A phase select either keeps the pattern as it is, so clock edges coincide with data transitions, or inverts it, so clock edges fall in the middle of each data bit.

The configuration inputs are static. After any change to `ser_factor`, `div_sel` or `phase_sel`, the user applies reset. A combination that cannot be built raises an error flag and holds the output low.

Top module: `fwd_clk_pattern_gen`

## Requirements
- R1: A clock edge with `rst_n` low makes `ser_out` and `cfg_err` both 0 from the next cycle on. This holds whatever the phase select is.
- R2: After reset is released with a legal configuration, the first clock edge emits word position 0. With `phase_sel`=0 that bit is 1.
- R3: With the ratio 1 (`div_sel`=0), position p of each word emits 1 when p is even and 0 when p is odd. With an odd word length, the last bit of a word and the first bit of the next word are therefore both 1.
- R4: With the ratio N = 2, 4, 8 or 10 (`div_sel` = 1, 2, 3, 4), each run of N bits is N/2 ones followed by N/2 zeros.
- R5: A word position counter runs from 0 to `ser_factor`-1 and wraps to 0. Every word begins at the start of the pattern.
- R6: With `phase_sel`=1, every emitted bit of a legal configuration is the inverse of the bit emitted with `phase_sel`=0.
- R7: A configuration is legal when all three of these hold: `ser_factor` is 4, 6, 7, 8 or 10; `div_sel` is 0 to 4; and the ratio divides `ser_factor` exactly. Any other configuration gives `cfg_err`=1 and `ser_out`=0 from the first edge after reset release. Examples are the ratio 4 with a factor of 10, and `div_sel` 5 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ser | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_factor | input | 4 | Serialization factor: bits per word, as a binary value |
| div_sel | input | 3 | Clock ratio code: 0 to 4 select 1, 2, 4, 8 and 10 |
| phase_sel | input | 1 | 0 keeps the pattern (edge aligned), 1 inverts it (center aligned) |
| ser_out | output | 1 | Serial bit sent to the lane |
| cfg_err | output | 1 | Configuration cannot be built |

## Verification
The hardest case to reach from the ports is a word boundary on which the pattern restart actually changes the bit sequence. That only happens with the ratio 1 and the odd word length 7, which produces two ones in a row. With every other legal combination the restart coincides with the natural repeat. The stimulus sweeps every factor code from 4 to 10 against every ratio code and both phases, resets between configurations, and runs each one for more than three words. This covers the odd-length boundary, the legal and illegal pairs, and the first bit after each reset release.

// File: rtl/fcpg_pkg.sv
// Shared widths and configuration decoding for the forwarded clock pattern
// generator. Assumes the serializer supports word lengths up to 10 bits.
package fcpg_pkg;
    localparam int FACTOR_W = 4;                 // width of the word length code
    localparam int DIVSEL_W = 3;                 // width of the ratio code
    localparam int POS_W    = FACTOR_W;          // word position counter width
    localparam int RATIO_W  = FACTOR_W;          // decoded ratio width

    typedef logic [FACTOR_W-1:0] factor_t;
    typedef logic [DIVSEL_W-1:0] divsel_t;
    typedef logic [POS_W-1:0]    pos_t;
    typedef logic [RATIO_W-1:0]  ratio_t;

    // Map a ratio code to its divide value; 0 means unsupported code.
    function automatic ratio_t decode_ratio(input divsel_t sel);
        case (sel)
            3'd0:    decode_ratio = 4'd1;
            3'd1:    decode_ratio = 4'd2;
            3'd2:    decode_ratio = 4'd4;
            3'd3:    decode_ratio = 4'd8;
            3'd4:    decode_ratio = 4'd10;
            default: decode_ratio = 4'd0;
        endcase
    endfunction

    // True for the word lengths the serializer supports.
    function automatic logic factor_supported(input factor_t f);
        case (f)
            4'd4, 4'd6, 4'd7, 4'd8, 4'd10: factor_supported = 1'b1;
            default:                       factor_supported = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/fcpg_cfg_check.sv
// Configuration checker: decodes the ratio code and decides whether the
// ratio fits the word length. Purely combinational; inputs assumed static.
module fcpg_cfg_check
    import fcpg_pkg::*;
(
    input  factor_t ser_factor,
    input  divsel_t div_sel,
    output ratio_t  ratio,
    output logic    cfg_ok
);
    ratio_t rem;

    // Decode the ratio and test that it divides the word length.
    always_comb begin
        ratio  = decode_ratio(div_sel);
        rem    = '0;
        cfg_ok = 1'b0;
        if (ratio != '0 && factor_supported(ser_factor)) begin
            rem    = ser_factor % ratio;
            cfg_ok = (rem == '0);
        end
    end
endmodule

// File: rtl/fcpg_word_counter.sv
// Word position counter: tracks the serial bit index within the current
// word, mirroring the load boundary of the data lanes. Assumes ser_factor is
// stable while running; held at zero while the configuration is illegal.
module fcpg_word_counter
    import fcpg_pkg::*;
(
    input  logic    clk_ser,
    input  logic    rst_n,
    input  logic    run,
    input  factor_t ser_factor,
    output pos_t    pos,
    output logic    word_last
);
    assign word_last = (pos == pos_t'(ser_factor - factor_t'(1)));

    // Advance the bit index and wrap it at the end of each word.
    always_ff @(posedge clk_ser) begin
        if (!rst_n || !run)   pos <= '0;
        else if (word_last)   pos <= '0;
        else                  pos <= pos + pos_t'(1);
    end

    assert_wrap_to_zero_R5: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (run && word_last) |=> (pos == '0));
    assert_pos_in_word_R5: assert property (@(posedge clk_ser) disable iff (!rst_n)
        run |-> (pos < ser_factor));
endmodule

// File: rtl/fcpg_pattern_core.sv
// Pattern core: produces the unphased clock bit for the current position.
// Ratio 1 uses position parity; larger ratios use a period counter that
// restarts at every word boundary. Assumes the ratio divides the word length.
module fcpg_pattern_core
    import fcpg_pkg::*;
(
    input  logic   clk_ser,
    input  logic   rst_n,
    input  logic   run,
    input  ratio_t ratio,
    input  pos_t   pos,
    input  logic   word_last,
    output logic   pat_bit
);
    ratio_t per_cnt;
    logic   per_last;

    assign per_last = (per_cnt == ratio - ratio_t'(1));

    // Count bits within one clock period and restart at word boundaries.
    always_ff @(posedge clk_ser) begin
        if (!rst_n || !run)         per_cnt <= '0;
        else if (word_last || per_last) per_cnt <= '0;
        else                        per_cnt <= per_cnt + ratio_t'(1);
    end

    // High for the first half of each period; parity for the ratio 1.
    always_comb begin
        if (ratio == ratio_t'(1)) pat_bit = ~pos[0];
        else                      pat_bit = (per_cnt < (ratio >> 1));
    end

    assert_period_range_R4: assert property (@(posedge clk_ser) disable iff (!rst_n)
        run |-> (per_cnt < ratio));
endmodule

// File: rtl/fwd_clk_pattern_gen.sv
// Forwarded clock pattern generator top: combines the configuration check,
// the word position counter and the pattern core, applies the phase
// inversion and registers the serial bit. Configuration is assumed static
// between resets.
module fwd_clk_pattern_gen
    import fcpg_pkg::*;
(
    input  logic                clk_ser,
    input  logic                rst_n,
    input  logic [FACTOR_W-1:0] ser_factor,
    input  logic [DIVSEL_W-1:0] div_sel,
    input  logic                phase_sel,
    output logic                ser_out,
    output logic                cfg_err
);
    ratio_t ratio;
    logic   cfg_ok;
    pos_t   pos;
    logic   word_last;
    logic   pat_bit;

    fcpg_cfg_check u_cfg (
        .ser_factor (ser_factor),
        .div_sel    (div_sel),
        .ratio      (ratio),
        .cfg_ok     (cfg_ok)
    );

    fcpg_word_counter u_word (
        .clk_ser    (clk_ser),
        .rst_n      (rst_n),
        .run        (cfg_ok),
        .ser_factor (ser_factor),
        .pos        (pos),
        .word_last  (word_last)
    );

    fcpg_pattern_core u_pat (
        .clk_ser    (clk_ser),
        .rst_n      (rst_n),
        .run        (cfg_ok),
        .ratio      (ratio),
        .pos        (pos),
        .word_last  (word_last),
        .pat_bit    (pat_bit)
    );

    // Register the phased serial bit and the error flag.
    always_ff @(posedge clk_ser) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            ser_out <= cfg_ok ? (pat_bit ^ phase_sel) : 1'b0;
            cfg_err <= ~cfg_ok;
        end
    end

    assert_reset_clears_R1: assert property (@(posedge clk_ser)
        !rst_n |=> (!ser_out && !cfg_err));
    assert_error_holds_low_R7: assert property (@(posedge clk_ser) disable iff (!rst_n)
        cfg_err |-> !ser_out);
    assert_word_start_high_R2: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (cfg_ok && pos == '0 && !phase_sel) |=> ser_out);
    assert_word_start_inverted_R6: assert property (@(posedge clk_ser) disable iff (!rst_n)
        (cfg_ok && pos == '0 && phase_sel) |=> !ser_out);
endmodule

// File: tb/fwd_clk_pattern_gen_tb.sv
// Bench: sweeps every configuration, resets between them, and compares the
// outputs on every cycle against a behavioural model written with integers.
module fwd_clk_pattern_gen_tb_top;
    logic       clk_ser = 1'b0;
    logic       rst_n;
    logic [3:0] ser_factor;
    logic [2:0] div_sel;
    logic       phase_sel;
    logic       ser_out;
    logic       cfg_err;

    always #5 clk_ser = ~clk_ser;

    fwd_clk_pattern_gen dut_i (
        .clk_ser    (clk_ser),
        .rst_n      (rst_n),
        .ser_factor (ser_factor),
        .div_sel    (div_sel),
        .phase_sel  (phase_sel),
        .ser_out    (ser_out),
        .cfg_err    (cfg_err)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    int    m_pos = 0;
    int    m_bits = 0;
    logic  exp_out = 1'b0;
    logic  exp_err = 1'b0;
    string exp_tag = "R1";

    function automatic int ref_ratio(input int code);
        int r[5] = '{1, 2, 4, 8, 10};
        if (code < 5) return r[code];
        return 0;
    endfunction

    function automatic bit ref_legal(input int f, input int code);
        int n;
        n = ref_ratio(code);
        if (!(f == 4 || f == 6 || f == 7 || f == 8 || f == 10)) return 0;
        if (n == 0) return 0;
        return (f % n) == 0;
    endfunction

    // Reference model: predicts the outputs after each rising edge.
    always @(posedge clk_ser) begin
        int n;
        int f;
        bit b;
        f = int'(ser_factor);
        n = ref_ratio(int'(div_sel));
        if (!rst_n) begin
            exp_out = 1'b0; exp_err = 1'b0; m_pos = 0; m_bits = 0; exp_tag = "R1";
        end else if (!ref_legal(f, int'(div_sel))) begin
            exp_out = 1'b0; exp_err = 1'b1; exp_tag = "R7";
        end else begin
            if (n == 1) b = (m_pos % 2) == 0;
            else        b = ((m_pos % n) * 2) < n;
            exp_out = b ^ phase_sel;
            exp_err = 1'b0;
            if (m_bits == 0)             exp_tag = "R2";
            else if (phase_sel)          exp_tag = "R6";
            else if (m_pos == 0)         exp_tag = "R5";
            else if (n == 1)             exp_tag = "R3";
            else                         exp_tag = "R4";
            m_pos  = (m_pos + 1) % f;
            m_bits = m_bits + 1;
        end
    end

    task automatic compare_now();
        n_cmp++;
        if (ser_out !== exp_out || cfg_err !== exp_err) begin
            n_bad++;
            $display("FAIL %s factor=%0d div_sel=%0d phase=%0d: out=%b err=%b expected out=%b err=%b",
                     exp_tag, ser_factor, div_sel, phase_sel, ser_out, cfg_err, exp_out, exp_err);
        end
    endtask

    initial begin
        rst_n = 1'b0; ser_factor = 4'd4; div_sel = 3'd0; phase_sel = 1'b0;
        @(negedge clk_ser);
        compare_now();                                 // R1 reset state
        for (int f = 4; f <= 10; f++) begin
            for (int d = 0; d < 8; d++) begin
                for (int ph = 0; ph < 2; ph++) begin
                    rst_n = 1'b0;
                    ser_factor = 4'(f); div_sel = 3'(d); phase_sel = 1'(ph);
                    @(negedge clk_ser); compare_now(); // R1 with new config
                    rst_n = 1'b1;
                    for (int k = 0; k < 3 * f + 2; k++) begin
                        @(negedge clk_ser); compare_now();
                    end
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_ser);
        n_bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule